// File: doc/BRIEF.md
# Dynamic Bus Sizing Master Controller

This block is the bus-master side of an external data path whose slaves may be 8 or 16 bits wide. A client hands it one operand request: one, two, three or four bytes, a direction and a starting byte address. The block then runs as many asynchronous external bus cycles as the operand needs. In each cycle the slave answers with a two-bit active-low acknowledge. That answer either holds the cycle in a wait state or ends it and reports the port width. From the width and the address, the sequencer decides how many bytes the cycle moved, then advances the address and the remaining count to match.

Bytes move most significant first. Write bytes are steered onto the data lanes the addressed port actually uses. Read bytes are collected from those lanes into a right-justified 32-bit result. Every cycle starts on the assumption of a 16-bit port and offers as many bytes as the remaining count and the address alignment allow. A slave that turns out to be narrower simply takes fewer bytes, and the rest follow in later cycles. When nothing remains, a one-cycle completion pulse is given.

Top module: `dynsz_bus_master`

## Requirements
- R1: A request is taken at a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no operand is in progress. `bus_strobe` is high in the cycle after acceptance, with `bus_addr` equal to the requested address.
- R2: `bus_siz` always reports the bytes still to move: 01 for one, 10 for two, 11 for three, 00 for four. `req_size` uses the same code.
- R3: While `bus_ack_n` is 11 (wait) or 00 (reserved), the cycle is held. `bus_strobe`, `bus_addr`, `bus_siz` and `bus_dout` stay unchanged, and no byte is counted.
- R4: `bus_ack_n` = 10 ends the cycle as an 8-bit port. Exactly one byte moves, on lanes [15:8], and the address rises by 1 while the remaining count falls by 1.
- R5: `bus_ack_n` = 01 at an even address with two or more bytes remaining moves two bytes. The earlier byte is on [15:8] and the later one on [7:0]. The address rises by 2 and the count falls by 2.
- R6: On a 16-bit acknowledge at an odd address, or with one byte left, only one byte moves: from [7:0] at an odd address, from [15:8] at an even one. Whenever only one byte can go, a write drives that byte on both lanes.
- R7: Between two bus cycles of the same operand, `bus_strobe` is low for exactly one clock.
- R8: Bytes go in order from the most significant byte of the operand down. Write data is taken right-justified from `req_wdata`.
- R9: `done` is high for exactly one clock, the cycle after the edge that accepted the final byte. A read's assembled right-justified result appears on `rdata` in that cycle and stays until the next read completes. Writes leave it unchanged.
- R10: `bus_rw` is 1 for a read and 0 for a write. `bus_doe` is high only during the strobe of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operand request present |
| req_write | input | 1 | 1 = write operand, 0 = read |
| req_size | input | 2 | Operand byte count (01/10/11/00 = 1/2/3/4) |
| req_addr | input | AW | Starting byte address |
| req_wdata | input | 32 | Write operand, right-justified |
| req_ready | output | 1 | Idle, a request can be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read operand, right-justified |
| bus_strobe | output | 1 | External bus cycle active |
| bus_rw | output | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | output | AW | Current byte address |
| bus_siz | output | 2 | Bytes remaining, same code as req_size |
| bus_dout | output | 16 | Write data lanes |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | 16 | Read data lanes |
| bus_ack_n | input | 2 | Slave acknowledge, [1] and [0] active low |

## Verification
Inputs change on falling edges, and outputs are sampled on falling edges. A request driven on one falling edge therefore shows `bus_strobe` with its address and size at the next falling edge. An acknowledge driven on a falling edge takes effect at the rising edge that follows. So the gap (strobe low) or the `done` pulse with `rdata` is checked one falling edge after the acknowledge, and the next bus cycle is checked one falling edge after that. Write lanes are checked in the half cycle where the acknowledge is applied, before the edge that consumes them. Wait and reserved codes are held for whole cycles, and at each of those samples the address, size and lanes are compared with the values from the cycle's first sample.

// File: rtl/dynsz_pkg.sv
package dynsz_pkg;
  localparam int CNT_W = 3;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_GAP  = 2'd2
  } sq_state_t;

  localparam logic [1:0] ACKN_BYTE = 2'b10;
  localparam logic [1:0] ACKN_HALF = 2'b01;

  function automatic logic [CNT_W-1:0] siz_count(input logic [1:0] code);
    return (code == 2'b00) ? CNT_W'(4) : {1'b0, code};
  endfunction
endpackage

// File: rtl/dynsz_lanes.sv
module dynsz_lanes
  import dynsz_pkg::*;
(
  input  logic             addr_lsb,
  input  logic [CNT_W-1:0] rem,
  input  logic [1:0]       ack_n,
  input  logic [7:0]       out_hi,
  input  logic [7:0]       out_nx,
  input  logic [15:0]      din,
  output logic             ack_done,
  output logic             take2,
  output logic [15:0]      rd_bytes,
  output logic [15:0]      dout
);
  logic port8, port16, wide_ok;

  always_comb begin
    port8    = (ack_n == ACKN_BYTE);
    port16   = (ack_n == ACKN_HALF);
    ack_done = port8 | port16;
    wide_ok  = !addr_lsb && (rem >= CNT_W'(2));
    take2    = port16 && wide_ok;
    if (take2)
      rd_bytes = din;
    else if (port16 && addr_lsb)
      rd_bytes = {8'h00, din[7:0]};
    else
      rd_bytes = {8'h00, din[15:8]};
    dout = {out_hi, (wide_ok ? out_nx : out_hi)};
  end
endmodule

// File: rtl/dynsz_seq.sv
module dynsz_seq
  import dynsz_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_size,
  input  logic [AW-1:0]    req_addr,
  input  logic             ack_done,
  input  logic             take2,
  output logic             req_ready,
  output logic             strobe,
  output logic             load,
  output logic             step,
  output logic             last,
  output logic [AW-1:0]    cur_addr,
  output logic [CNT_W-1:0] rem,
  output logic             done
);
  sq_state_t        st_q, st_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [CNT_W-1:0] rem_q, rem_d, nrem;
  logic             done_q;

  always_comb begin
    load  = (st_q == SQ_IDLE) && req_valid;
    step  = (st_q == SQ_RUN) && ack_done;
    nrem  = rem_q - (take2 ? CNT_W'(2) : CNT_W'(1));
    last  = step && (nrem == '0);
    st_d   = st_q;
    addr_d = addr_q;
    rem_d  = rem_q;
    case (st_q)
      SQ_IDLE: if (load) begin
        st_d   = SQ_RUN;
        addr_d = req_addr;
        rem_d  = siz_count(req_size);
      end
      SQ_RUN: if (step) begin
        st_d   = last ? SQ_IDLE : SQ_GAP;
        addr_d = addr_q + (take2 ? AW'(2) : AW'(1));
        rem_d  = nrem;
      end
      SQ_GAP:  st_d = SQ_RUN;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      if (load || step) begin
        addr_q <= addr_d;
        rem_q  <= rem_d;
      end
      done_q <= last;
    end
  end

  assign req_ready = (st_q == SQ_IDLE);
  assign strobe    = (st_q == SQ_RUN);
  assign cur_addr  = addr_q;
  assign rem       = rem_q;
  assign done      = done_q;

  a_r1_start: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> (strobe && cur_addr == $past(req_addr)));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !ack_done) |=> (strobe && $stable(cur_addr) && $stable(rem)));
  a_r7_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last) |=> !strobe);
  a_r7_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_GAP) |=> strobe);
  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_live: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (rem != '0));
endmodule

// File: rtl/dynsz_data.sv
module dynsz_data
  import dynsz_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  input  logic        step,
  input  logic        last,
  input  logic        take2,
  input  logic [15:0] rd_bytes,
  output logic        is_wr,
  output logic [7:0]  out_hi,
  output logic [7:0]  out_nx,
  output logic [31:0] rdata
);
  logic [31:0] sh_q, sh_d, acc_q, acc_d, rd_q;
  logic        wr_q;

  always_comb begin
    sh_d  = sh_q;
    acc_d = acc_q;
    if (load) begin
      case (req_size)
        2'b01:   sh_d = req_wdata << 24;
        2'b10:   sh_d = req_wdata << 16;
        2'b11:   sh_d = req_wdata << 8;
        default: sh_d = req_wdata;
      endcase
      acc_d = '0;
    end else if (step) begin
      sh_d  = take2 ? (sh_q << 16) : (sh_q << 8);
      acc_d = take2 ? {acc_q[15:0], rd_bytes} : {acc_q[23:0], rd_bytes[7:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      acc_q <= '0;
      rd_q  <= '0;
      wr_q  <= 1'b0;
    end else begin
      if (load || step) begin
        sh_q  <= sh_d;
        acc_q <= acc_d;
      end
      if (load) wr_q <= req_write;
      if (last && !wr_q) rd_q <= acc_d;
    end
  end

  assign is_wr  = wr_q;
  assign out_hi = sh_q[31:24];
  assign out_nx = sh_q[23:16];
  assign rdata  = rd_q;

  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(last && !wr_q) |=> $stable(rdata));
  a_r8_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !take2 && !last) |=> (out_hi == $past(out_nx)));
endmodule

// File: rtl/dynsz_bus_master.sv
module dynsz_bus_master
  import dynsz_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [31:0]   rdata,
  output logic          bus_strobe,
  output logic          bus_rw,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_siz,
  output logic [15:0]   bus_dout,
  output logic          bus_doe,
  input  logic [15:0]   bus_din,
  input  logic [1:0]    bus_ack_n
);
  logic             rst_m, rst_i;
  logic             load, step, last, ack_done, take2, is_wr;
  logic [CNT_W-1:0] rem;
  logic [AW-1:0]    cur_addr;
  logic [7:0]       out_hi, out_nx;
  logic [15:0]      rd_bytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_i <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_i <= rst_m;
    end
  end

  dynsz_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_i), .req_valid(req_valid), .req_size(req_size),
    .req_addr(req_addr), .ack_done(ack_done), .take2(take2),
    .req_ready(req_ready), .strobe(bus_strobe), .load(load), .step(step),
    .last(last), .cur_addr(cur_addr), .rem(rem), .done(done)
  );

  dynsz_lanes u_lanes (
    .addr_lsb(cur_addr[0]), .rem(rem), .ack_n(bus_ack_n), .out_hi(out_hi),
    .out_nx(out_nx), .din(bus_din), .ack_done(ack_done), .take2(take2),
    .rd_bytes(rd_bytes), .dout(bus_dout)
  );

  dynsz_data u_data (
    .clk(clk), .rst_n(rst_i), .load(load), .req_write(req_write),
    .req_size(req_size), .req_wdata(req_wdata), .step(step), .last(last),
    .take2(take2), .rd_bytes(rd_bytes), .is_wr(is_wr), .out_hi(out_hi),
    .out_nx(out_nx), .rdata(rdata)
  );

  assign bus_rw   = !is_wr;
  assign bus_doe  = bus_strobe && is_wr;
  assign bus_addr = cur_addr;
  assign bus_siz  = rem[1:0];
endmodule

// File: tb/dynsz_bus_master_tb.sv
module dynsz_bus_master_tb;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]    req_size = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          req_ready, done, bus_strobe, bus_rw, bus_doe;
  logic [31:0]   rdata;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_siz;
  logic [15:0]   bus_dout;
  logic [15:0]   bus_din = '0;
  logic [1:0]    bus_ack_n = 2'b11;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] last_rd = '0;

  always #10 clk = ~clk;

  dynsz_bus_master #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .rdata(rdata),
    .bus_strobe(bus_strobe), .bus_rw(bus_rw), .bus_addr(bus_addr),
    .bus_siz(bus_siz), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din), .bus_ack_n(bus_ack_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rb(input logic [AW-1:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction

  // Runs one operand against a slave of the given width; checks every cycle.
  task automatic run_op(input bit wr, input int n, input logic [AW-1:0] a,
                        input logic [31:0] wd, input bit p16, input int waits,
                        input bit use_rsv);
    int rem = n;
    int k = 0;
    logic [AW-1:0] cur = a;
    logic [31:0] exp_rd = '0;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready when idle", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = wr; req_size = n[1:0];
    req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (rem > 0) begin
      int m;
      logic [15:0] d0;
      logic [7:0] opk, opn;
      chk(bus_strobe === 1'b1, "R1 strobe on", {31'd0, bus_strobe}, 32'd1);
      chk(req_ready === 1'b0, "R1 busy not ready", {31'd0, req_ready}, 32'd0);
      chk(bus_addr === cur, "R4 R5 address", 32'(bus_addr), 32'(cur));
      chk(bus_siz === rem[1:0], "R2 siz code", {30'd0, bus_siz}, 32'(rem[1:0]));
      chk(bus_rw === !wr && bus_doe === wr, "R10 direction",
          {30'd0, bus_rw, bus_doe}, {30'd0, !wr, wr});
      d0 = bus_dout;
      for (int w = 0; w < waits; w++) begin
        bus_ack_n = (use_rsv && w == 0) ? 2'b00 : 2'b11;
        @(negedge clk);
        chk(bus_strobe === 1'b1 && bus_addr === cur && bus_siz === rem[1:0],
            "R3 held in wait", {7'd0, bus_strobe, bus_addr}, {7'd0, 1'b1, cur});
        if (wr) chk(bus_dout === d0, "R3 lanes stable", 32'(bus_dout), 32'(d0));
      end
      m = p16 ? ((cur[0] || rem == 1) ? 1 : 2) : 1;
      opk = wd[8*(n-1-k) +: 8];
      opn = (k + 1 < n) ? wd[8*(n-2-k) +: 8] : 8'h00;
      if (wr) begin
        if (m == 2)
          chk(bus_dout === {opk, opn}, "R5 R8 two lanes", 32'(bus_dout), {16'd0, opk, opn});
        else begin
          chk(bus_dout[15:8] === opk, "R4 R8 upper lane", 32'(bus_dout[15:8]), 32'(opk));
          if (cur[0] || rem == 1)
            chk(bus_dout[7:0] === opk, "R6 copy lane", 32'(bus_dout[7:0]), 32'(opk));
        end
      end
      if (p16) bus_din = {rb({cur[AW-1:1], 1'b0}), rb({cur[AW-1:1], 1'b1})};
      else     bus_din = {rb(cur), 8'hE7};
      bus_ack_n = p16 ? 2'b01 : 2'b10;
      for (int i = 0; i < m; i++) exp_rd = (exp_rd << 8) | 32'(rb(cur + AW'(i)));
      @(negedge clk);
      bus_ack_n = 2'b11;
      bus_din = 16'hDEAD;
      rem -= m; k += m; cur = cur + AW'(m);
      if (rem > 0) begin
        chk(bus_strobe === 1'b0 && done === 1'b0, "R7 gap", {30'd0, bus_strobe, done}, 32'd0);
        @(negedge clk);
      end else begin
        chk(done === 1'b1 && bus_strobe === 1'b0, "R9 done pulse", {30'd0, done, bus_strobe}, 32'd2);
        if (!wr) begin
          chk(rdata === exp_rd, "R9 R8 read result", rdata, exp_rd);
          last_rd = exp_rd;
        end else
          chk(rdata === last_rd, "R9 rdata kept on write", rdata, last_rd);
        @(negedge clk);
        chk(done === 1'b0, "R9 single pulse", {31'd0, done}, 32'd0);
        if (!wr) chk(rdata === last_rd, "R9 rdata held", rdata, last_rd);
      end
    end
  endtask

  task automatic t_reset();
    chk(req_ready === 1'b1 && bus_strobe === 1'b0 && done === 1'b0 && bus_doe === 1'b0,
        "R1 reset state", {28'd0, req_ready, bus_strobe, done, bus_doe}, 32'h8);
  endtask

  task automatic t_long_read16();  run_op(0, 4, 24'h000100, 32'h0, 1, 0, 0); endtask
  task automatic t_long_read8();   run_op(0, 4, 24'h000208, 32'h0, 0, 0, 0); endtask
  task automatic t_word_write_odd(); run_op(1, 2, 24'h000201, 32'h0000A1B2, 1, 0, 0); endtask
  task automatic t_three_read_odd(); run_op(0, 3, 24'h000303, 32'h0, 1, 0, 0); endtask
  task automatic t_byte_read_odd();  run_op(0, 1, 24'h000407, 32'h0, 1, 0, 0); endtask
  task automatic t_long_write8_wait(); run_op(1, 4, 24'h000510, 32'h11223344, 0, 3, 1); endtask
  task automatic t_long_write16();   run_op(1, 4, 24'h000600, 32'hCAFEF00D, 1, 2, 1); endtask
  task automatic t_word_read8_wait(); run_op(0, 2, 24'h000711, 32'h0, 0, 2, 0); endtask
  task automatic t_three_write_even(); run_op(1, 3, 24'h000820, 32'h00778899, 1, 0, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_long_read16();
    t_long_read8();
    t_word_write_odd();
    t_three_read_odd();
    t_byte_read_odd();
    t_long_write8_wait();
    t_long_write16();
    t_word_read8_wait();
    t_three_write_even();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule